// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block looks at 32 pending-interrupt request lines and picks the one the processor should take next. Each source has its own enable bit, and one global enable gates all of them. The sources are grouped in fours. Each group shares a 2-bit priority level, and level 3 is the most urgent.

The arbiter finds the highest level held by any pending, enabled source. At that level it picks the lowest-numbered source and registers the result as a winner number with a valid flag. Configuration is loaded through a simple byte-wide write port. A rising edge on the acknowledge input echoes the current winner on a separate one-cycle ack output, so the owner of that request can clear its pending flag.

Top module: `irq_grp_arb`

## Requirements
- R1: After reset `irq_valid_o`, `irq_id_o`, `ack_valid_o` and `ack_id_o` are 0. The global enable, every source enable bit and every group level are also 0.
- R2: While the global enable is 0, `irq_valid_o` stays low, whatever the requests and enable bits are.
- R3: A source whose enable bit is 0 never wins. If no enabled source is pending, `irq_valid_o` is low.
- R4: Write map, taking effect at the clock edge where `wr_en_i` is high:
  - Address 0, bit 0 is the global enable.
  - Addresses 1 to 4 hold the enable bits for sources 0-7, 8-15, 16-23 and 24-31, with the lowest source in bit 0.
  - Address 5 holds the levels of groups 0-3.
  - Address 6 holds the levels of groups 4-7.
  - In addresses 5 and 6, each group takes two bits, and the lower group sits in the lower bits.
- R5: Group g is made up of sources 4g to 4g+3, and all four use that group's level.
- R6: A pending, enabled source at a higher level beats every source at a lower level. Level 3 is the highest and level 0 the lowest.
- R7: Among candidates at the same level, whether they are in the same group or in different groups, the lowest source number wins.
- R8: The winner is registered. `irq_valid_o`/`irq_id_o` reflect the requests and configuration present at the previous clock edge. Whenever `irq_valid_o` is low, `irq_id_o` is 0.
- R9: A rising edge of `ack_i` while `irq_valid_o` is high raises `ack_valid_o` for exactly one cycle, with `ack_id_o` equal to the winner that was shown at that edge. At all other times `ack_valid_o` and `ack_id_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 32 | Pending request per source |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 3 | Configuration register address |
| wr_data_i | input | 8 | Configuration write data |
| ack_i | input | 1 | Acknowledge of the current winner (edge detected) |
| irq_valid_o | output | 1 | A winner is being reported |
| irq_id_o | output | 5 | Winning source number, 0 when not valid |
| ack_valid_o | output | 1 | One-cycle pulse marking an accepted acknowledge |
| ack_id_o | output | 5 | Source number that was acknowledged |

## Verification
The bench sets up several cases to check how the level comparison and the index comparison interact:
- A high-numbered source in a level-3 group must beat source 0 at level 0. A design that only looks at source numbers would report source 0 instead.
- Two sources at the same level, first in different groups and then in the same group, must resolve to the lower number. A reversed priority encoder would return the higher one.
- Masking out the would-be winner must hand the win to the next candidate, not drop `irq_valid_o`.
- Clearing the global enable must silence everything.

A write to the wrong mask byte shows up as the wrong source winning. An ack held high for two cycles must pulse only once.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    parameter int NUM_SRC  = 32;
    parameter int GRP_SIZE = 4;
    parameter int LVL_W    = 2;
    parameter int ADDR_W   = 3;
    parameter int DATA_W   = 8;

    localparam int NUM_GRP  = NUM_SRC / GRP_SIZE;
    localparam int NUM_LVL  = 1 << LVL_W;
    localparam int ID_W     = $clog2(NUM_SRC);
    localparam int PRIO_W   = NUM_GRP * LVL_W;
    localparam int MASK_REGS = NUM_SRC / DATA_W;
    localparam int PRIO_REGS = PRIO_W / DATA_W;

    localparam logic [ADDR_W-1:0] ADDR_CTRL      = '0;
    localparam logic [ADDR_W-1:0] ADDR_MASK_BASE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_PRIO_BASE = ADDR_W'(1 + MASK_REGS);

    typedef logic [ID_W-1:0]  id_t;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic                glob_en;
        logic [NUM_SRC-1:0]  mask;
        logic [PRIO_W-1:0]   prio;
    } cfg_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_arb_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output cfg_t              cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            if (wr_addr_i == ADDR_CTRL) begin
                cfg_d.glob_en = wr_data_i[0];
            end
            for (int r = 0; r < MASK_REGS; r++) begin
                if (wr_addr_i == ADDR_MASK_BASE + ADDR_W'(r)) begin
                    cfg_d.mask[r*DATA_W +: DATA_W] = wr_data_i;
                end
            end
            for (int r = 0; r < PRIO_REGS; r++) begin
                if (wr_addr_i == ADDR_PRIO_BASE + ADDR_W'(r)) begin
                    cfg_d.prio[r*DATA_W +: DATA_W] = wr_data_i;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R4: with no write strobe the configuration holds
    a_r4_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(cfg_q));
endmodule

// File: rtl/irq_level_max.sv
module irq_level_max
    import irq_arb_pkg::*;
(
    input  logic [NUM_SRC-1:0] cand_i,
    input  logic [PRIO_W-1:0]  prio_i,
    output logic               any_o,
    output lvl_t               max_lvl_o,
    output logic [NUM_SRC-1:0] at_max_o
);
    lvl_t src_lvl [NUM_SRC];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int GRP = i / GRP_SIZE;
        assign src_lvl[i] = prio_i[GRP*LVL_W +: LVL_W];
        assign at_max_o[i] = cand_i[i] && (src_lvl[i] == max_lvl_o);
    end

    always_comb begin
        max_lvl_o = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (cand_i[i] && src_lvl[i] == lvl_t'(l)) max_lvl_o = lvl_t'(l);
            end
        end
    end

    assign any_o = |cand_i;

    // R6: a pending candidate always leaves at least one source at the top level
    always_comb begin
        a_r6_top_nonempty: assert (!any_o || (at_max_o != '0));
    end
endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick
    import irq_arb_pkg::*;
(
    input  logic [NUM_SRC-1:0] vec_i,
    output logic               found_o,
    output id_t                id_o
);
    always_comb begin
        found_o = 1'b0;
        id_o    = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                id_o    = id_t'(i);
            end
        end
    end

    // R7: the chosen source is set and no lower source is set
    always_comb begin
        a_r7_lowest: assert (!found_o ||
            (vec_i[id_o] && ((vec_i & ((NUM_SRC'(1) << id_o) - NUM_SRC'(1))) == '0)));
    end
endmodule

// File: rtl/irq_grp_arb.sv
module irq_grp_arb
    import irq_arb_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [31:0]       req_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              ack_i,
    output logic              irq_valid_o,
    output logic [4:0]        irq_id_o,
    output logic              ack_valid_o,
    output logic [4:0]        ack_id_o
);
    typedef struct packed {
        logic valid;
        id_t  id;
        logic ack_valid;
        id_t  ack_id;
        logic ack_prev;
    } arb_st_t;

    cfg_t               cfg;
    logic [NUM_SRC-1:0] cand, at_max;
    logic               any_cand, found;
    lvl_t               max_lvl;
    id_t                win_id;
    arb_st_t            st_d, st_q;

    irq_cfg_regs u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .cfg_o     (cfg)
    );

    assign cand = cfg.glob_en ? (req_i & cfg.mask) : '0;

    irq_level_max u_lvl (
        .cand_i    (cand),
        .prio_i    (cfg.prio),
        .any_o     (any_cand),
        .max_lvl_o (max_lvl),
        .at_max_o  (at_max)
    );

    irq_low_pick u_pick (
        .vec_i   (at_max),
        .found_o (found),
        .id_o    (win_id)
    );

    always_comb begin
        st_d           = st_q;
        st_d.valid     = any_cand && found;
        st_d.id        = (any_cand && found) ? win_id : '0;
        st_d.ack_prev  = ack_i;
        st_d.ack_valid = ack_i && !st_q.ack_prev && st_q.valid;
        st_d.ack_id    = (ack_i && !st_q.ack_prev && st_q.valid) ? st_q.id : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign irq_valid_o = st_q.valid;
    assign irq_id_o    = st_q.id;
    assign ack_valid_o = st_q.ack_valid;
    assign ack_id_o    = st_q.ack_id;

    logic [NUM_SRC-1:0] live;
    assign live = req_i & cfg.mask;

    // R2: a reported winner needs the global enable at the previous edge
    a_r2_valid_needs_ge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_valid_o |-> $past(cfg.glob_en));
    // R3: the reported source was pending and enabled at the previous edge
    a_r3_winner_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_valid_o |-> (($past(live) >> irq_id_o) & NUM_SRC'(1)) != '0);
    // R8: idle output reports source 0
    a_r8_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_valid_o |-> irq_id_o == '0);
    // R9: ack pulse lasts one cycle and carries the prior winner
    a_r9_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_valid_o |=> !ack_valid_o);
    a_r9_ack_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_valid_o |-> ack_id_o == $past(irq_id_o));
endmodule

// File: tb/irq_grp_arb_test.sv
`timescale 1ns/1ps
module irq_grp_arb_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ack = 1'b0;
    logic        irq_valid, ack_valid;
    logic [4:0]  irq_id, ack_id;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    irq_grp_arb uut (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .ack_i(ack), .irq_valid_o(irq_valid), .irq_id_o(irq_id),
        .ack_valid_o(ack_valid), .ack_id_o(ack_id)
    );

    typedef struct packed {
        logic        ge;
        logic [31:0] mask;
        logic [15:0] prio;
        logic [31:0] req;
        logic        valid;
        logic [4:0]  id;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'hFFFF_FFFF, 16'h0000, 32'h0000_0000, 1'b0, 5'd0,  4'd8}, // R8 nothing pending
        '{1'b1, 32'hFFFF_FFFF, 16'h0000, 32'h0000_0100, 1'b1, 5'd8,  4'd5}, // R5 single source
        '{1'b1, 32'hFFFF_FFFF, 16'h0000, 32'h8000_0011, 1'b1, 5'd0,  4'd7}, // R7 reset levels
        '{1'b1, 32'hFFFF_FFFF, 16'hC000, 32'h8000_0011, 1'b1, 5'd31, 4'd6}, // R6 group7 at 3
        '{1'b1, 32'hFFFF_FFFF, 16'hC000, 32'h3000_0000, 1'b1, 5'd28, 4'd7}, // R7 same group
        '{1'b1, 32'hFFFF_FFFF, 16'h0820, 32'h0020_0200, 1'b1, 5'd9,  4'd7}, // R7 equal level groups
        '{1'b1, 32'hFFFF_FDFF, 16'h0820, 32'h0020_0200, 1'b1, 5'd21, 4'd3}, // R3 winner masked
        '{1'b0, 32'hFFFF_FFFF, 16'h0000, 32'hFFFF_FFFF, 1'b0, 5'd0,  4'd2}, // R2 global off
        '{1'b1, 32'h0000_0000, 16'h0000, 32'hFFFF_FFFF, 1'b0, 5'd0,  4'd3}, // R3 all masked
        '{1'b1, 32'hFFFF_FFFF, 16'h4004, 32'h8000_0080, 1'b1, 5'd7,  4'd7}, // R7 level1 tie
        '{1'b1, 32'hFFFF_FFFF, 16'h4004, 32'h8000_0001, 1'b1, 5'd31, 4'd6}, // R6 level1 over 0
        '{1'b1, 32'hFFFF_FFFF, 16'h2340, 32'h0101_1000, 1'b1, 5'd16, 4'd6}, // R6 three levels
        '{1'b1, 32'h00FF_0000, 16'h0000, 32'h0080_8000, 1'b1, 5'd23, 4'd4}  // R4 mask byte 2
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input logic ge, input logic [31:0] m, input logic [15:0] p);
        wr(3'd0, {7'd0, ge});
        for (int b = 0; b < 4; b++) wr(3'(1 + b), m[b*8 +: 8]);
        wr(3'd5, p[7:0]);
        wr(3'd6, p[15:8]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, with requests present but nothing enabled
        req = 32'hFFFF_FFFF;
        repeat (2) @(negedge clk);
        check("R1", "valid", irq_valid, 0);
        check("R1", "id", irq_id, 0);
        check("R1", "ack_valid", ack_valid, 0);
        check("R1", "ack_id", ack_id, 0);
        // R1: mask reset to 0 -> setting only global enable yields nothing
        wr(3'd0, 8'h01);
        repeat (2) @(negedge clk);
        check("R1", "valid after ge only", irq_valid, 0);

        for (int k = 0; k < NV; k++) begin
            req = '0;
            load(VEC[k].ge, VEC[k].mask, VEC[k].prio);
            req = VEC[k].req;
            repeat (2) @(negedge clk);
            check(tag_name(VEC[k].tag), $sformatf("vec%0d valid", k), irq_valid, VEC[k].valid);
            check(tag_name(VEC[k].tag), $sformatf("vec%0d id", k), irq_id, VEC[k].id);
        end

        // R8: output registered, changes one edge after req
        load(1'b1, 32'hFFFF_FFFF, 16'h0000);
        req = 32'h0000_0000;
        repeat (2) @(negedge clk);
        req = 32'h0000_0040;
        #1;
        check("R8", "valid before edge", irq_valid, 0);
        @(negedge clk);
        check("R8", "valid after edge", irq_valid, 1);
        check("R8", "id after edge", irq_id, 6);

        // R9: ack held two cycles pulses once with winner id
        ack = 1'b1;
        @(negedge clk);
        check("R9", "ack_valid pulse", ack_valid, 1);
        check("R9", "ack_id", ack_id, 6);
        @(negedge clk);
        check("R9", "ack_valid second cycle", ack_valid, 0);
        check("R9", "ack_id second cycle", ack_id, 0);
        ack = 1'b0;
        // R9: ack with no winner gives no pulse
        req = '0;
        repeat (2) @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        check("R9", "ack_valid idle", ack_valid, 0);
        ack = 1'b0;
        @(negedge clk);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R8 watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule